// File: doc/BRIEF.md
# Load-Store Memory Access Stage

This block is the memory-access step of a 32-bit in-order pipeline. Each cycle it takes the operation held in the preceding pipeline latch: a kind (load, store or idle), an access-size code, a byte address and the data to store. From these it drives one word-wide data memory port with an aligned word address, a per-byte write-enable mask and lane-shifted write data. Loads pick one byte lane from the returned word and extend it, or take the full word. The result is registered, together with the ALU value, program counter and jump flag, into the latch that feeds writeback.

Every partial store becomes a single aligned word write. This covers single bytes and the two halves of an unaligned word store: the part that runs up from the address and the part that runs down from it. The low two address bits choose the enable mask and the shift of the store data. The memory signals that it can accept the access by raising a ready input. While a load or store waits for ready, the stage raises a stall output and the writeback latch keeps its contents.

Top module: `lsu_mem_stage`

## Requirements
- R1: While `in_op` requests a load (1) or store (2) and `mem_ready` is low, `stall` is 1 and `mem_req` stays 1. When `mem_ready` is high, or when there is no request, `stall` is 0.
- R2: A signed-byte load (`in_width`=0) returns the byte on lane `in_addr[1:0]` of `mem_rdata`, where lane k is bits 8k+7..8k, sign-extended to 32 bits.
- R3: An unsigned-byte load (`in_width`=1) returns the same lane byte zero-extended to 32 bits.
- R4: A load with any other width code returns `mem_rdata` unchanged. A word load uses `in_width`=2.
- R5: A byte store (`in_width` 0 or 1) sets exactly the `mem_be` bit at index `in_addr[1:0]` and places `in_wdata[7:0]` in all four lanes of `mem_wdata`.
- R6: A word store (`in_width`=2) sets `mem_be`=1111 and passes `in_wdata` unchanged. For every request, `mem_addr` is `in_addr` with its low two bits cleared.
- R7: A right-part store (`in_width`=3) with lane L sets `mem_be` = 1111 shifted left by L, trimmed to four bits, and `mem_wdata` = `in_wdata` shifted left by 8·L. At L=0 the full word is written.
- R8: A left-part store (`in_width`=4) with lane L sets `mem_be` = 1111 shifted right by 3−L and `mem_wdata` = `in_wdata` shifted right by 8·(3−L). At L=3 the full word goes to the aligned word at address−3.
- R9: An idle operation (`in_op` 0 or 3) keeps `mem_req` and `mem_we` at 0 and registers a result of zero. A store also registers a zero result.
- R10: On every non-stalled cycle, `in_op`, `in_alu`, `in_pc` and `in_jump` are registered unchanged into `wb_op`, `wb_alu`, `wb_pc` and `wb_jump`. The result is registered into `wb_result` on the same edge.
- R11: A synchronous active-high reset clears `wb_op`, `wb_result`, `wb_alu`, `wb_pc` and `wb_jump` to zero.
- R12: While `stall` is 1, all writeback outputs keep their values across the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_op | input | 2 | Operation kind: 0 idle, 1 load, 2 store, 3 idle |
| in_width | input | 3 | Size code: 0 signed byte, 1 unsigned byte, 2 word, 3 right part, 4 left part |
| in_addr | input | 32 | Byte address |
| in_wdata | input | 32 | Store data |
| in_alu | input | 32 | ALU value passed to writeback |
| in_pc | input | 32 | Program counter passed to writeback |
| in_jump | input | 1 | Jump flag passed to writeback |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Aligned word address |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Read word from memory |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| stall | output | 1 | Stage is waiting on memory |
| wb_op | output | 2 | Registered operation kind |
| wb_result | output | 32 | Registered load result |
| wb_alu | output | 32 | Registered ALU value |
| wb_pc | output | 32 | Registered program counter |
| wb_jump | output | 1 | Registered jump flag |

## Verification
The bench drives every lane of both partial-store kinds, including the two edge lanes where they become full-word writes. A design with a swapped shift direction or an off-by-one mask would write the wrong bytes or shifted data there. Signed loads are run on lane bytes with the top bit set and clear, to catch a design that extends from the wrong bit or returns the unselected lane. The memory is held not-ready for several cycles on both a load and a store, so a design that latched during a stall would show a changed result before ready returns. Idle operations are fed a non-zero read word, which exposes a result that leaks memory data.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_STORE = 2'd2,
      OP_RSVD  = 2'd3
   } lsu_op_e;

   typedef enum logic [2:0] {
      SZ_SBYTE = 3'd0,
      SZ_UBYTE = 3'd1,
      SZ_WORD  = 3'd2,
      SZ_RPART = 3'd3,
      SZ_LPART = 3'd4
   } lsu_size_e;
endpackage

// File: rtl/lsu_store_align.sv
module lsu_store_align #(
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8,
   localparam int LB    = $clog2(BYTES)
) (
   input  logic [2:0]        size,
   input  logic [LB-1:0]     lane,
   input  logic [DATA_W-1:0] wdata,
   output logic [BYTES-1:0]  be,
   output logic [DATA_W-1:0] data
);
   import lsu_pkg::*;

   localparam logic [BYTES-1:0] ALL_EN = {BYTES{1'b1}};

   int unsigned up_sh;
   int unsigned dn_sh;

   always_comb begin
      up_sh = int'(lane);
      dn_sh = (BYTES - 1) - int'(lane);
      unique case (size)
         SZ_SBYTE, SZ_UBYTE: begin
            be   = BYTES'(1) << lane;
            data = {BYTES{wdata[7:0]}};
         end
         SZ_RPART: begin
            be   = ALL_EN << up_sh;
            data = wdata << (8 * up_sh);
         end
         SZ_LPART: begin
            be   = ALL_EN >> dn_sh;
            data = wdata >> (8 * dn_sh);
         end
         default: begin
            be   = ALL_EN;
            data = wdata;
         end
      endcase
   end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8,
   localparam int LB    = $clog2(BYTES)
) (
   input  logic [2:0]        size,
   input  logic [LB-1:0]     lane,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] result
);
   import lsu_pkg::*;

   logic [7:0] lane_byte [BYTES];
   logic [7:0] picked;

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      assign lane_byte[g] = rdata[8*g +: 8];
   end

   assign picked = lane_byte[lane];

   always_comb begin
      unique case (size)
         SZ_SBYTE: result = {{(DATA_W-8){picked[7]}}, picked};
         SZ_UBYTE: result = {{(DATA_W-8){1'b0}}, picked};
         default:  result = rdata;
      endcase
   end
endmodule

// File: rtl/lsu_mem_stage.sv
module lsu_mem_stage #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        in_op,
   input  logic [2:0]        in_width,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_wdata,
   input  logic [DATA_W-1:0] in_alu,
   input  logic [ADDR_W-1:0] in_pc,
   input  logic              in_jump,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic              stall,
   output logic [1:0]        wb_op,
   output logic [DATA_W-1:0] wb_result,
   output logic [DATA_W-1:0] wb_alu,
   output logic [ADDR_W-1:0] wb_pc,
   output logic              wb_jump
);
   import lsu_pkg::*;

   localparam int BYTES = DATA_W / 8;
   localparam int LB    = $clog2(BYTES);

   if (DATA_W % 8 != 0 || BYTES < 2 || (1 << LB) != BYTES) begin : g_bad_data_w
      $error("lsu_mem_stage: DATA_W must be a power-of-two number of bytes");
   end
   if (ADDR_W <= LB) begin : g_bad_addr_w
      $error("lsu_mem_stage: ADDR_W too small for lane select");
   end

   logic              is_load;
   logic              is_store;
   logic [LB-1:0]     lane;
   logic [DATA_W-1:0] load_val;

   assign is_load  = (in_op == OP_LOAD);
   assign is_store = (in_op == OP_STORE);
   assign lane     = in_addr[LB-1:0];

   assign mem_req  = is_load | is_store;
   assign mem_we   = is_store;
   assign mem_addr = {in_addr[ADDR_W-1:LB], {LB{1'b0}}};
   assign stall    = mem_req & ~mem_ready;

   lsu_store_align #(.DATA_W(DATA_W)) u_align (
      .size  (in_width),
      .lane  (lane),
      .wdata (in_wdata),
      .be    (mem_be),
      .data  (mem_wdata)
   );

   lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
      .size   (in_width),
      .lane   (lane),
      .rdata  (mem_rdata),
      .result (load_val)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         wb_op     <= OP_IDLE;
         wb_result <= '0;
         wb_alu    <= '0;
         wb_pc     <= '0;
         wb_jump   <= 1'b0;
      end else if (!stall) begin
         wb_op     <= in_op;
         wb_result <= is_load ? load_val : '0;
         wb_alu    <= in_alu;
         wb_pc     <= in_pc;
         wb_jump   <= in_jump;
      end
   end
endmodule

// File: rtl/lsu_mem_stage_chk.sv
module lsu_mem_stage_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8,
   localparam int LB    = $clog2(BYTES)
) (
   input logic              clk,
   input logic              rst,
   input logic [1:0]        in_op,
   input logic [2:0]        in_width,
   input logic [LB-1:0]     in_lane,
   input logic              mem_req,
   input logic              mem_we,
   input logic [BYTES-1:0]  mem_be,
   input logic              stall,
   input logic [1:0]        wb_op,
   input logic [DATA_W-1:0] wb_result,
   input logic [DATA_W-1:0] wb_alu,
   input logic [ADDR_W-1:0] wb_pc
);
   assert_reset_clear_R11: assert property (@(posedge clk)
      rst |=> (wb_op == 2'd0 && wb_result == '0 && wb_pc == '0));

   assert_stall_hold_R12: assert property (@(posedge clk) disable iff (rst)
      stall |=> ($stable(wb_result) && $stable(wb_pc) && $stable(wb_alu) && $stable(wb_op)));

   assert_sign_ext_R2: assert property (@(posedge clk) disable iff (rst)
      (!stall && in_op == 2'd1 && in_width == 3'd0)
      |=> (wb_result[DATA_W-1:8] == {(DATA_W-8){wb_result[7]}}));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      (in_op == 2'd0 || in_op == 2'd3) |-> (!mem_req && !mem_we));

   assert_byte_onehot_R5: assert property (@(posedge clk) disable iff (rst)
      (mem_we && (in_width == 3'd0 || in_width == 3'd1)) |-> ($countones(mem_be) == 1));

   assert_right_full_R7: assert property (@(posedge clk) disable iff (rst)
      (mem_we && in_width == 3'd3 && in_lane == '0) |-> (&mem_be));

   assert_left_full_R8: assert property (@(posedge clk) disable iff (rst)
      (mem_we && in_width == 3'd4 && in_lane == '1) |-> (&mem_be));
endmodule

bind lsu_mem_stage lsu_mem_stage_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_op     (in_op),
   .in_width  (in_width),
   .in_lane   (in_addr[LB-1:0]),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_be    (mem_be),
   .stall     (stall),
   .wb_op     (wb_op),
   .wb_result (wb_result),
   .wb_alu    (wb_alu),
   .wb_pc     (wb_pc)
);

// File: tb/lsu_mem_stage_tb.sv
`timescale 1ns/1ps
module lsu_mem_stage_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic [1:0]  in_op;
   logic [2:0]  in_width;
   logic [31:0] in_addr, in_wdata, in_alu, in_pc;
   logic        in_jump;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata, mem_rdata;
   logic        mem_ready;
   logic        stall;
   logic [1:0]  wb_op;
   logic [31:0] wb_result, wb_alu, wb_pc;
   logic        wb_jump;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   lsu_mem_stage u_dut (
      .clk(clk), .rst(rst), .in_op(in_op), .in_width(in_width), .in_addr(in_addr),
      .in_wdata(in_wdata), .in_alu(in_alu), .in_pc(in_pc), .in_jump(in_jump),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .stall(stall), .wb_op(wb_op), .wb_result(wb_result), .wb_alu(wb_alu),
      .wb_pc(wb_pc), .wb_jump(wb_jump)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic drive(logic [1:0] op, logic [2:0] sz, logic [31:0] addr, logic [31:0] wd,
                        logic [31:0] rd, logic rdy, logic [31:0] pc);
      @(negedge clk);
      in_op = op; in_width = sz; in_addr = addr; in_wdata = wd;
      mem_rdata = rd; mem_ready = rdy; in_pc = pc; in_alu = addr ^ 32'h0F0F_0000;
      in_jump = pc[2];
      #1;
   endtask

   task automatic after_edge();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      in_op = 2'd1; in_width = 3'd2; in_addr = 32'h40; in_wdata = 0; in_alu = 1;
      in_pc = 4; in_jump = 1; mem_rdata = 32'hFFFF_FFFF; mem_ready = 1'b1;
      after_edge(); after_edge();
      check("R11 wb_op", {30'd0, wb_op}, 32'd0);
      check("R11 wb_result", wb_result, 32'd0);
      check("R11 wb_alu", wb_alu, 32'd0);
      check("R11 wb_pc", wb_pc, 32'd0);
      check("R11 wb_jump", {31'd0, wb_jump}, 32'd0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_load(string tag, logic [2:0] sz, logic [31:0] addr, logic [31:0] rd,
                         logic [31:0] exp);
      drive(2'd1, sz, addr, 32'hDEAD_BEEF, rd, 1'b1, addr + 32'h1000);
      check({tag, " mem_req"}, {31'd0, mem_req}, 32'd1);
      check({tag, " mem_we"}, {31'd0, mem_we}, 32'd0);
      check({tag, " stall"}, {31'd0, stall}, 32'd0);
      check("R6 mem_addr aligned", mem_addr, {addr[31:2], 2'b00});
      after_edge();
      check({tag, " wb_result"}, wb_result, exp);
      check("R10 wb_op", {30'd0, wb_op}, 32'd1);
      check("R10 wb_alu", wb_alu, addr ^ 32'h0F0F_0000);
      check("R10 wb_pc", wb_pc, addr + 32'h1000);
      check("R10 wb_jump", {31'd0, wb_jump}, {31'd0, addr[2]});
   endtask

   task automatic t_store(string tag, logic [2:0] sz, logic [31:0] addr, logic [31:0] wd,
                          logic [31:0] exp_addr, logic [3:0] exp_be, logic [31:0] exp_data);
      drive(2'd2, sz, addr, wd, 32'h1234_5678, 1'b1, 32'h2000);
      check({tag, " mem_we"}, {31'd0, mem_we}, 32'd1);
      check({tag, " mem_addr"}, mem_addr, exp_addr);
      check({tag, " mem_be"}, {28'd0, mem_be}, {28'd0, exp_be});
      check({tag, " mem_wdata"}, mem_wdata, exp_data);
      after_edge();
      check("R9 store result zero", wb_result, 32'd0);
   endtask

   task automatic t_idle(logic [1:0] op);
      drive(op, 3'd2, 32'h0000_0055, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 1'b1, 32'h3000);
      check("R9 idle mem_req", {31'd0, mem_req}, 32'd0);
      check("R9 idle mem_we", {31'd0, mem_we}, 32'd0);
      check("R1 idle no stall", {31'd0, stall}, 32'd0);
      after_edge();
      check("R9 idle result", wb_result, 32'd0);
      check("R9 idle wb_op", {30'd0, wb_op}, {30'd0, op});
      check("R10 idle wb_alu", wb_alu, 32'h0F0F_0055);
      check("R10 idle wb_pc", wb_pc, 32'h3000);
   endtask

   task automatic t_stall();
      t_load("R4 pre-stall", 3'd2, 32'h500, 32'hCAFE_F00D, 32'hCAFE_F00D);
      for (int i = 0; i < 3; i++) begin
         drive(2'd1, 3'd2, 32'h504, 0, 32'h0BAD_0BAD, 1'b0, 32'h6000);
         check("R1 load stall", {31'd0, stall}, 32'd1);
         check("R1 req held", {31'd0, mem_req}, 32'd1);
         after_edge();
         check("R12 result held", wb_result, 32'hCAFE_F00D);
         check("R12 pc held", wb_pc, 32'h1500);
      end
      drive(2'd1, 3'd2, 32'h504, 0, 32'h7777_1111, 1'b1, 32'h6000);
      check("R1 ready clears stall", {31'd0, stall}, 32'd0);
      after_edge();
      check("R1 load completes", wb_result, 32'h7777_1111);
      check("R10 pc after stall", wb_pc, 32'h6000);
      for (int i = 0; i < 2; i++) begin
         drive(2'd2, 3'd2, 32'h508, 32'h1, 0, 1'b0, 32'h7000);
         check("R1 store stall", {31'd0, stall}, 32'd1);
         after_edge();
         check("R12 pc held store", wb_pc, 32'h6000);
         check("R12 result held store", wb_result, 32'h7777_1111);
      end
      drive(2'd2, 3'd2, 32'h508, 32'h1, 0, 1'b1, 32'h7000);
      check("R1 store ready", {31'd0, stall}, 32'd0);
      after_edge();
      check("R10 store pc", wb_pc, 32'h7000);
   endtask

   task automatic t_mid_reset();
      t_load("R4 pre-reset", 3'd2, 32'h600, 32'h1357_9BDF, 32'h1357_9BDF);
      @(negedge clk);
      rst = 1'b1;
      after_edge();
      check("R11 mid-run result", wb_result, 32'd0);
      check("R11 mid-run pc", wb_pc, 32'd0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      t_reset();
      // loads
      t_load("R2 signed neg", 3'd0, 32'h401, 32'h1122_8033, 32'hFFFF_FF80);
      t_load("R2 signed pos", 3'd0, 32'h403, 32'h7F00_00FF, 32'h0000_007F);
      t_load("R3 unsigned", 3'd1, 32'h402, 32'h00F0_0000, 32'h0000_00F0);
      t_load("R3 unsigned lane0", 3'd1, 32'h404, 32'hFFFF_FF9C, 32'h0000_009C);
      t_load("R4 word", 3'd2, 32'h408, 32'h8765_4321, 32'h8765_4321);
      // stores
      t_store("R5 byte", 3'd0, 32'h302, 32'h1234_56EF, 32'h300, 4'b0100, 32'hEFEF_EFEF);
      t_store("R5 ubyte", 3'd1, 32'h307, 32'h0000_0011, 32'h304, 4'b1000, 32'h1111_1111);
      t_store("R6 word", 3'd2, 32'h30C, 32'hA1B2_C3D4, 32'h30C, 4'b1111, 32'hA1B2_C3D4);
      t_store("R7 right L0", 3'd3, 32'h100, 32'hA1B2_C3D4, 32'h100, 4'b1111, 32'hA1B2_C3D4);
      t_store("R7 right L1", 3'd3, 32'h101, 32'hA1B2_C3D4, 32'h100, 4'b1110, 32'hB2C3_D400);
      t_store("R7 right L2", 3'd3, 32'h10A, 32'hA1B2_C3D4, 32'h108, 4'b1100, 32'hC3D4_0000);
      t_store("R7 right L3", 3'd3, 32'h10B, 32'hA1B2_C3D4, 32'h108, 4'b1000, 32'hD400_0000);
      t_store("R8 left L0", 3'd4, 32'h208, 32'hA1B2_C3D4, 32'h208, 4'b0001, 32'h0000_00A1);
      t_store("R8 left L1", 3'd4, 32'h205, 32'hA1B2_C3D4, 32'h204, 4'b0011, 32'h0000_A1B2);
      t_store("R8 left L2", 3'd4, 32'h206, 32'hA1B2_C3D4, 32'h204, 4'b0111, 32'h00A1_B2C3);
      t_store("R8 left L3", 3'd4, 32'h207, 32'hA1B2_C3D4, 32'h204, 4'b1111, 32'hA1B2_C3D4);
      // idle
      t_idle(2'd0);
      t_idle(2'd3);
      // stall and reset
      t_stall();
      t_mid_reset();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule